// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller

This block gathers six interrupt sources for a small CPU core: two external request pins, three timer overflow strobes and one serial-port flag. It holds a pending state for each source, masks that state with a master enable and one enable bit per source, and picks the pending source with the highest priority. It then presents a single request line and a 3-bit source index to the CPU.

Each external pin is active low and passes through a synchronizer. A per-pin select bit makes the pin either falling-edge sensitive or low-level sensitive. An edge request and a timer overflow are each latched in a flag inside the block. That flag is cleared when the CPU acknowledges the same index. A level request and the serial flag are not latched: they follow their inputs and ignore the acknowledge. The serial flag is owned and cleared by software in the serial block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Source indices are fixed: 0 external pin 0, 1 timer 0, 2 external pin 1, 3 timer 1, 4 serial, 5 timer 2. When several enabled sources are pending, the lowest index is presented.
- R2: While `glb_en_i` is 0, `irq_o` is 0 and `irq_idx_o` is 0. Pending flags are kept and are presented again once `glb_en_i` returns to 1.
- R3: Bit k of `src_en_i` gates source k. A pending source whose bit is 0 is never presented, and lower-priority sources win in its place.
- R4: With `ext_edge_sel_i[n]` = 1, a high-to-low transition on `ext_n_i[n]` sets a flag. The flag stays set after the pin returns high. A pin held low after that flag is acknowledged raises no further request.
- R5: With `ext_edge_sel_i[n]` = 0, pin n requests while it is low and stops requesting once it is high. An acknowledge does not remove this request.
- R6: An acknowledge (`ack_i` = 1 with `ack_idx_i` = k) clears only the latched flag of source k. Every other pending flag is kept.
- R7: A one-cycle high on `tmr_ovf_i[t]` latches a flag for timer t. Bit 0 maps to index 1, bit 1 to index 3 and bit 2 to index 5. The flag holds until that index is acknowledged.
- R8: `ser_flag_i` requests while high. An acknowledge of index 4 has no effect on it.
- R9: `irq_o` and `irq_idx_o` are registered. After a timer strobe sampled at one clock edge, the request appears at the following edge.
- R10: Synchronous active-low reset clears all flags and drives `irq_o` and `irq_idx_o` to 0.
- R11: The pin synchronizers reset to the idle-high state. A pin that is high when reset is released produces no request in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_n_i | input | 2 | External request pins, active low, asynchronous |
| ext_edge_sel_i | input | 2 | Per-pin sensitivity: 1 falling edge, 0 low level |
| tmr_ovf_i | input | 3 | Timer overflow strobes for timers 0, 1, 2 |
| ser_flag_i | input | 1 | Serial port interrupt flag, level |
| glb_en_i | input | 1 | Master interrupt enable |
| src_en_i | input | 6 | Per-source enables, bit k gates index k |
| ack_i | input | 1 | CPU enters service this cycle |
| ack_idx_i | input | 3 | Index being serviced |
| irq_o | output | 1 | Request to the CPU |
| irq_idx_o | output | 3 | Index of the winning source |

## Verification
The assertions assume three things about the inputs. Timer strobes are single-cycle pulses. `ack_idx_i` holds a valid index (0 to 5) whenever `ack_i` is high. The select bits do not change while a pin transition is still in the synchronizer. The stimulus follows these rules: it pulses strobes and acknowledges for exactly one cycle, always acknowledges an index the test has made pending or deliberately chosen, and sets the select bits with the pins idle and several settle cycles before any pin toggles.

// File: rtl/irq_pkg.sv
// Package: shared constants and the source index map for the interrupt
// controller. Assumes exactly six sources with a fixed, non-programmable order.
package irq_pkg;
    localparam int NUM_SRC = 6;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int NUM_EXT = 2;
    localparam int NUM_TMR = 3;

    // Index of each source; lower value means higher priority.
    typedef enum logic [IDX_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5
    } src_e;
endpackage

// File: rtl/irq_ext_detect.sv
// Module: one external request pin. Synchronizes the active-low pin,
// detects falling edges and keeps an edge flag, or passes the level through.
// Assumes edge_mode is static while a transition is in the synchronizer.
module irq_ext_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic ack_clr,
    output logic req
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   flag_q;
    logic                   pin_s;
    logic                   fall;

    // Synchronizer chain, reset to idle high so release gives no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q[0] <= pin_n;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    // Previous synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_s;
    end

    assign fall = prev_q & ~pin_s;

    // Edge flag: set on fall, cleared on acknowledge, unused in level mode.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (!edge_mode) flag_q <= 1'b0;
        else if (fall)       flag_q <= 1'b1;
        else if (ack_clr)    flag_q <= 1'b0;
    end

    // Request selection between latched edge and live level.
    assign req = edge_mode ? flag_q : ~pin_s;

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mode && fall |=> flag_q); // R4
    AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mode && ack_clr && !fall |=> !flag_q); // R6
endmodule

// File: rtl/irq_flag_bank.sv
// Module: holds the timer overflow flags and assembles the six-bit pending
// vector in priority order. Decodes the acknowledge into per-source clears.
// Assumes timer strobes are single-cycle and ack_idx is valid with ack.
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_req,
    input  logic [NUM_TMR-1:0] tmr_ovf,
    input  logic               ser_flag,
    input  logic               ack,
    input  logic [IDX_W-1:0]   ack_idx,
    output logic [NUM_EXT-1:0] ext_ack,
    output logic [NUM_SRC-1:0] pend
);
    // Index of each timer and each external pin in the priority map.
    localparam logic [IDX_W-1:0] TMR_IDX [NUM_TMR] = '{SRC_TMR0, SRC_TMR1, SRC_TMR2};
    localparam logic [IDX_W-1:0] EXT_IDX [NUM_EXT] = '{SRC_EXT0, SRC_EXT1};

    logic [NUM_TMR-1:0] tmr_flag_q;
    logic [NUM_TMR-1:0] tmr_ack;

    genvar g;
    generate
        for (g = 0; g < NUM_TMR; g++) begin : g_tmr
            assign tmr_ack[g] = ack && (ack_idx == TMR_IDX[g]);

            // Timer flag: set on overflow (wins over ack), cleared on ack.
            always_ff @(posedge clk) begin
                if (!rst_n)           tmr_flag_q[g] <= 1'b0;
                else if (tmr_ovf[g])  tmr_flag_q[g] <= 1'b1;
                else if (tmr_ack[g])  tmr_flag_q[g] <= 1'b0;
            end

            AST_TMR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
                tmr_ovf[g] |=> tmr_flag_q[g]); // R7
            AST_TMR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
                tmr_flag_q[g] && !tmr_ack[g] |=> tmr_flag_q[g]); // R6
        end

        for (g = 0; g < NUM_EXT; g++) begin : g_ext
            assign ext_ack[g] = ack && (ack_idx == EXT_IDX[g]);
        end
    endgenerate

    // Pending vector in priority order.
    always_comb begin
        pend           = '0;
        pend[SRC_EXT0] = ext_req[0];
        pend[SRC_TMR0] = tmr_flag_q[0];
        pend[SRC_EXT1] = ext_req[1];
        pend[SRC_TMR1] = tmr_flag_q[1];
        pend[SRC_SER]  = ser_flag;
        pend[SRC_TMR2] = tmr_flag_q[2];
    end
endmodule

// File: rtl/irq_prio_arb.sv
// Module: masks pending requests with the master and per-source enables and
// registers the lowest-index winner as the CPU request and index.
// Assumes the pending vector is already synchronous to clk.
module irq_prio_arb
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    input  logic               glb_en,
    input  logic [NUM_SRC-1:0] src_en,
    output logic               irq,
    output logic [IDX_W-1:0]   irq_idx
);
    logic [NUM_SRC-1:0] masked;
    logic               win_vld;
    logic [IDX_W-1:0]   win_idx;

    assign masked = pend & src_en & {NUM_SRC{glb_en}};

    // Priority encoder: scanning downward leaves the lowest set index.
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (masked[i]) begin
                win_vld = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end

    // Output register for request line and index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            irq_idx <= '0;
        end else begin
            irq     <= win_vld;
            irq_idx <= win_idx;
        end
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_idx < IDX_W'(NUM_SRC))); // R1
    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> (!irq && irq_idx == '0)); // R2

    genvar k;
    generate
        for (k = 0; k < NUM_SRC; k++) begin : g_chk
            AST_SRC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
                !src_en[k] |=> !(irq && irq_idx == IDX_W'(k))); // R3
            AST_PRIO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
                masked[k] |=> (irq && irq_idx <= IDX_W'(k))); // R1
        end
    endgenerate
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: top of the fixed-priority interrupt controller. Wires two external
// pin detectors, the flag bank and the registered arbiter.
// Assumes all inputs except ext_n_i are synchronous to clk.
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_n_i,
    input  logic [NUM_EXT-1:0] ext_edge_sel_i,
    input  logic [NUM_TMR-1:0] tmr_ovf_i,
    input  logic               ser_flag_i,
    input  logic               glb_en_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               ack_i,
    input  logic [IDX_W-1:0]   ack_idx_i,
    output logic               irq_o,
    output logic [IDX_W-1:0]   irq_idx_o
);
    logic [NUM_EXT-1:0] ext_req;
    logic [NUM_EXT-1:0] ext_ack;
    logic [NUM_SRC-1:0] pend;

    genvar n;
    generate
        for (n = 0; n < NUM_EXT; n++) begin : g_pin
            irq_ext_detect #(
                .SYNC_STAGES (SYNC_STAGES)
            ) u_det (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin_n     (ext_n_i[n]),
                .edge_mode (ext_edge_sel_i[n]),
                .ack_clr   (ext_ack[n]),
                .req       (ext_req[n])
            );
        end
    endgenerate

    irq_flag_bank u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_req  (ext_req),
        .tmr_ovf  (tmr_ovf_i),
        .ser_flag (ser_flag_i),
        .ack      (ack_i),
        .ack_idx  (ack_idx_i),
        .ext_ack  (ext_ack),
        .pend     (pend)
    );

    irq_prio_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .glb_en  (glb_en_i),
        .src_en  (src_en_i),
        .irq     (irq_o),
        .irq_idx (irq_idx_o)
    );

    AST_SER_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ser_flag_i && glb_en_i && (src_en_i == '1) && ack_i && ack_idx_i == SRC_SER
        && (pend[3:0] == '0) |=> (irq_o && irq_idx_o == SRC_SER)); // R8
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_n = 2'b11;
    logic [1:0] edge_sel = 2'b11;
    logic [2:0] tmr_ovf = '0;
    logic       ser_flag = 1'b0;
    logic       glb_en = 1'b0;
    logic [5:0] src_en = '0;
    logic       ack = 1'b0;
    logic [2:0] ack_idx = '0;
    logic       irq;
    logic [2:0] irq_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_prio_ctrl u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .ext_n_i        (ext_n),
        .ext_edge_sel_i (edge_sel),
        .tmr_ovf_i      (tmr_ovf),
        .ser_flag_i     (ser_flag),
        .glb_en_i       (glb_en),
        .src_en_i       (src_en),
        .ack_i          (ack),
        .ack_idx_i      (ack_idx),
        .irq_o          (irq),
        .irq_idx_o      (irq_idx)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp_irq, input logic [2:0] exp_idx);
        n_chk++;
        if (irq !== exp_irq || irq_idx !== exp_idx) begin
            n_fail++;
            $display("FAIL %s: irq=%0b idx=%0d expected irq=%0b idx=%0d",
                     req, irq, irq_idx, exp_irq, exp_idx);
        end
    endtask

    task automatic pulse_tmr(input int t);
        tmr_ovf[t] = 1'b1;
        tick(1);
        tmr_ovf[t] = 1'b0;
        tick(1);
    endtask

    task automatic do_ack(input logic [2:0] idx);
        ack = 1'b1;
        ack_idx = idx;
        tick(1);
        ack = 1'b0;
        ack_idx = '0;
        tick(2);
    endtask

    // R10, R11: reset state and no spurious edge on release.
    task automatic t_reset;
        tick(3);
        check("R10 in reset", 1'b0, 3'd0);
        glb_en = 1'b1;
        src_en = '1;
        rst_n = 1'b1;
        tick(8);
        check("R11 no edge after release", 1'b0, 3'd0);
    endtask

    // R9: registered latency from a timer strobe.
    task automatic t_latency;
        tmr_ovf[0] = 1'b1;
        tick(1);
        tmr_ovf[0] = 1'b0;
        check("R9 not yet after one edge", 1'b0, 3'd0);
        tick(1);
        check("R9 present after two edges", 1'b1, 3'd1);
        do_ack(3'd1);
        check("R7 ack clears timer 0", 1'b0, 3'd0);
    endtask

    // R1, R7: fixed ordering among latched and level sources.
    task automatic t_priority;
        ser_flag = 1'b1;
        tick(2);
        check("R8 serial requests", 1'b1, 3'd4);
        pulse_tmr(2);
        check("R1 serial beats timer 2", 1'b1, 3'd4);
        pulse_tmr(1);
        check("R1 timer 1 beats serial", 1'b1, 3'd3);
        do_ack(3'd4);
        check("R8 ack 4 ignored", 1'b1, 3'd3);
        do_ack(3'd3);
        check("R6 after ack 3 serial next", 1'b1, 3'd4);
        ser_flag = 1'b0;
        tick(2);
        check("R7 timer 2 still held", 1'b1, 3'd5);
        do_ack(3'd5);
        check("R7 timer 2 cleared", 1'b0, 3'd0);
    endtask

    // R2: master enable masks without dropping flags.
    task automatic t_global;
        pulse_tmr(0);
        glb_en = 1'b0;
        tick(2);
        check("R2 masked by global", 1'b0, 3'd0);
        glb_en = 1'b1;
        tick(2);
        check("R2 flag kept", 1'b1, 3'd1);
        do_ack(3'd1);
    endtask

    // R3: per-source enable.
    task automatic t_src_en;
        ser_flag = 1'b1;
        src_en = 6'b101111;
        tick(2);
        check("R3 serial disabled", 1'b0, 3'd0);
        pulse_tmr(2);
        check("R3 timer 2 wins when serial off", 1'b1, 3'd5);
        src_en = '1;
        tick(2);
        check("R3 serial back", 1'b1, 3'd4);
        ser_flag = 1'b0;
        do_ack(3'd5);
        check("R3 cleanup", 1'b0, 3'd0);
    endtask

    // R4, R6: edge mode on pin 0 with a timer pending alongside.
    task automatic t_edge;
        edge_sel[0] = 1'b1;
        ext_n[0] = 1'b0;
        tick(6);
        check("R4 falling edge requests", 1'b1, 3'd0);
        ext_n[0] = 1'b1;
        tick(6);
        check("R4 flag held after pin high", 1'b1, 3'd0);
        pulse_tmr(0);
        do_ack(3'd0);
        check("R6 ack 0 keeps timer 0", 1'b1, 3'd1);
        do_ack(3'd1);
        check("R6 ack 1 clears timer 0", 1'b0, 3'd0);
        ext_n[0] = 1'b0;
        tick(6);
        do_ack(3'd0);
        tick(6);
        check("R4 held low gives no second request", 1'b0, 3'd0);
        ext_n[0] = 1'b1;
        tick(6);
    endtask

    // R5: level mode on pin 1.
    task automatic t_level;
        edge_sel[1] = 1'b0;
        tick(6);
        ext_n[1] = 1'b0;
        tick(6);
        check("R5 low level requests", 1'b1, 3'd2);
        do_ack(3'd2);
        check("R5 ack has no effect", 1'b1, 3'd2);
        ext_n[1] = 1'b1;
        tick(6);
        check("R5 released pin drops", 1'b0, 3'd0);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_latency();
        t_priority();
        t_global();
        t_src_en();
        t_edge();
        t_level();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule